// File: doc/BRIEF.md
# Hit Time-Stamp Encoder

This block turns one captured hit into a single binary time stamp. On the hit strobe it takes a snapshot of several interleaved delay lines and the values of two Gray-coded coarse counters. The delay lines are sampled as thermometer codes and are offset from one another by a fraction of a tap. The counters run half a reference cycle apart. Within one reference cycle the block encodes the hit position to a fine bin. Whether that bin falls in the early or the late half of the cycle decides which coarse counter is trusted, so a count captured next to its own transition is never used.

The delay lines, the counters and the capture latches lie outside the block. Their values arrive as inputs that are valid in the cycle the strobe is high. The result is registered and comes out one clock later as the concatenation of the binary coarse count and the fine bin. An error flag marks a tap snapshot that is not a clean thermometer code.

Top module: `tdc_stamp_enc`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle with `hit_i` high, and low otherwise.
- R2: Line 0 is `taps_i[TAPS-1:0]`. Bit k is 1 when the edge has passed tap k. A boundary at k means bit k is 0 and bit k-1 is 1, where bit -1 counts as 1. The tap index is the lowest boundary position, and it forms the stamp bits `[FINE_W-1:LINE_W]`.
- R3: Line l (l ≥ 1) is `taps_i[l*TAPS +: TAPS]` and leads line 0 by l/LINES of a tap. The stamp bits `[LINE_W-1:0]` give the number of lines l ≥ 1 whose bit at the line-0 tap index is 1. With the defaults, fine = tap_index*4 + that count, which spans 0..127.
- R4: When the fine MSB is 1 (second half of the cycle), the coarse field `stamp_o[CNT_W+FINE_W-1:FINE_W]` is the binary form of `cnt_early_i`, and `cnt_late_i` has no effect.
- R5: When the fine MSB is 0, the coarse field is the binary form of `cnt_late_i` minus one, modulo 2^CNT_W, and `cnt_early_i` has no effect.
- R6: The counters are reflected binary Gray code, g = b ^ (b >> 1). Conversion holds over the full CNT_W range, including the all-ones count.
- R7: `err_o` is 1 when line 0 has more than one boundary, or when any other line has more than one boundary. The index from the lowest boundary is still used.
- R8: When line 0 is all ones (no boundary), `err_o` is 1 and the tap index is TAPS-1. When every line is a clean code and line 0 is not all ones, `err_o` is 0. Lines l ≥ 1 that are all ones or all zeros are clean.
- R9: In a cycle without `hit_i`, `stamp_o` and `err_o` keep their previous values, whatever the taps and counters do.
- R10: During reset, `valid_o`, `stamp_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | Hit strobe; the taps and counters are valid in this cycle |
| taps_i | input | LINES*TAPS | Delay-line snapshots, line l at `[l*TAPS +: TAPS]` |
| cnt_early_i | input | CNT_W | Gray count that changes at the start of the cycle |
| cnt_late_i | input | CNT_W | Gray count that changes mid-cycle, one ahead in origin |
| valid_o | output | 1 | Stamp valid, one cycle after the hit |
| stamp_o | output | CNT_W+LINES_W... see note | `{coarse[CNT_W-1:0], fine[FINE_W-1:0]}`, width CNT_W+FINE_W |
| err_o | output | 1 | Tap snapshot was not a clean thermometer code |

## Verification
The bench uses the default parameters: 32 taps, 4 lines and 21-bit counters. This makes the 128-bin fine range and the 2^21 coarse range reachable, including fine bins 0, 63, 64 and 127 and the counter values 0 and all ones. Line snapshots come from a model of a true quarter-tap position. The bench drives the unselected counter with unrelated data, which shows that the selection is made from the fine half. Deliberate bubbles and an all-ones line 0 exercise the error path.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int unsigned TDC_TAPS  = 32;
  localparam int unsigned TDC_LINES = 4;
  localparam int unsigned TDC_CNT_W = 21;
endpackage

// File: rtl/tdc_therm_enc.sv
// Lowest 1->0 boundary of a thermometer snapshot; flags none or several.
module tdc_therm_enc #(
  parameter int unsigned TAPS  = tdc_pkg::TDC_TAPS,
  localparam int unsigned TAP_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]  taps_i,
  output logic [TAP_W-1:0] idx_o,
  output logic             bad_o
);
  logic [TAPS-1:0] bnd;

  assign bnd = ~taps_i & {taps_i[TAPS-2:0], 1'b1};

  always_comb begin
    idx_o = TAP_W'(TAPS - 1);
    for (int k = TAPS - 1; k >= 0; k--) begin
      if (bnd[k]) idx_o = TAP_W'(k);
    end
  end

  assign bad_o = (bnd == '0) || ((bnd & (bnd - 1'b1)) != '0);
endmodule

// File: rtl/tdc_bubble_det.sv
// Flags more than one boundary; an edge-free line is legal here.
module tdc_bubble_det #(
  parameter int unsigned TAPS = tdc_pkg::TDC_TAPS
) (
  input  logic [TAPS-1:0] taps_i,
  output logic            multi_o
);
  logic [TAPS-1:0] bnd;

  assign bnd     = ~taps_i & {taps_i[TAPS-2:0], 1'b1};
  assign multi_o = (bnd & (bnd - 1'b1)) != '0;
endmodule

// File: rtl/tdc_gray2bin.sv
module tdc_gray2bin #(
  parameter int unsigned W = tdc_pkg::TDC_CNT_W
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^(gray_i >> i);
  end
endmodule

// File: rtl/tdc_stamp_enc.sv
module tdc_stamp_enc #(
  parameter int unsigned TAPS   = tdc_pkg::TDC_TAPS,
  parameter int unsigned LINES  = tdc_pkg::TDC_LINES,
  parameter int unsigned CNT_W  = tdc_pkg::TDC_CNT_W,
  localparam int unsigned TAP_W  = $clog2(TAPS),
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned FINE_W = TAP_W + LINE_W,
  localparam int unsigned OUT_W  = CNT_W + FINE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hit_i,
  input  logic [LINES*TAPS-1:0] taps_i,
  input  logic [CNT_W-1:0]      cnt_early_i,
  input  logic [CNT_W-1:0]      cnt_late_i,
  output logic                  valid_o,
  output logic [OUT_W-1:0]      stamp_o,
  output logic                  err_o
);
  logic [TAP_W-1:0]  idx0;
  logic              bad0;
  logic [LINES-1:0]  multi;
  logic [LINE_W-1:0] ahead;
  logic [FINE_W-1:0] fine;
  logic [CNT_W-1:0]  early_bin, late_bin, coarse;
  logic              err_d;

  tdc_therm_enc #(.TAPS(TAPS)) i_enc0 (
    .taps_i (taps_i[TAPS-1:0]),
    .idx_o  (idx0),
    .bad_o  (bad0)
  );

  assign multi[0] = 1'b0;
  for (genvar l = 1; l < LINES; l++) begin : g_line
    tdc_bubble_det #(.TAPS(TAPS)) i_bub (
      .taps_i  (taps_i[l*TAPS +: TAPS]),
      .multi_o (multi[l])
    );
  end

  // Count leading lines already past the line-0 boundary tap
  always_comb begin
    ahead = '0;
    for (int l = 1; l < LINES; l++) begin
      ahead = ahead + LINE_W'(taps_i[l*TAPS + int'(idx0)]);
    end
  end

  assign fine  = {idx0, ahead};
  assign err_d = bad0 | (|multi);

  tdc_gray2bin #(.W(CNT_W)) i_g2b_early (.gray_i(cnt_early_i), .bin_o(early_bin));
  tdc_gray2bin #(.W(CNT_W)) i_g2b_late  (.gray_i(cnt_late_i),  .bin_o(late_bin));

  // Second half: early counter settled; first half: late counter, origin shifted by one
  assign coarse = fine[FINE_W-1] ? early_bin : late_bin - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      stamp_o <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= hit_i;
      if (hit_i) begin
        stamp_o <= {coarse, fine};
        err_o   <= err_d;
      end
    end
  end
endmodule

// File: rtl/tdc_stamp_enc_chk.sv
module tdc_stamp_enc_chk #(
  parameter int unsigned TAPS   = tdc_pkg::TDC_TAPS,
  parameter int unsigned LINES  = tdc_pkg::TDC_LINES,
  parameter int unsigned CNT_W  = tdc_pkg::TDC_CNT_W,
  localparam int unsigned TAP_W  = $clog2(TAPS),
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned FINE_W = TAP_W + LINE_W,
  localparam int unsigned OUT_W  = CNT_W + FINE_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  hit_i,
  input logic [LINES*TAPS-1:0] taps_i,
  input logic [CNT_W-1:0]      cnt_early_i,
  input logic [CNT_W-1:0]      cnt_late_i,
  input logic                  valid_o,
  input logic [OUT_W-1:0]      stamp_o,
  input logic                  err_o
);
  function automatic logic [CNT_W-1:0] to_bin(logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [TAPS-1:0] l0;
  logic            l0_clean;
  assign l0       = taps_i[TAPS-1:0];
  assign l0_clean = ((l0 & (l0 + 1'b1)) == '0) && !(&l0);

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> valid_o);
  // R1
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> !valid_o);
  // R2
  tap_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && l0_clean) |=> stamp_o[FINE_W-1:LINE_W] == TAP_W'($countones($past(l0))));
  // R4
  early_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && l0_clean && $countones(l0) >= TAPS/2)
      |=> stamp_o[OUT_W-1:FINE_W] == to_bin($past(cnt_early_i)));
  // R5
  late_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && l0_clean && $countones(l0) < TAPS/2)
      |=> stamp_o[OUT_W-1:FINE_W] == to_bin($past(cnt_late_i)) - 1'b1);
  // R8
  no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && (&l0)) |=> err_o && stamp_o[FINE_W-1:LINE_W] == '1);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(stamp_o) && $stable(err_o));
endmodule

bind tdc_stamp_enc tdc_stamp_enc_chk #(.TAPS(TAPS), .LINES(LINES), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_tdc_stamp_enc.sv
`timescale 1ns/1ps
module test_tdc_stamp_enc;
  localparam int TAPS = 32, LINES = 4, CNT_W = 21, FINE_W = 7, OUT_W = CNT_W + FINE_W;

  logic                  clk_i = 1'b0, rst_ni = 1'b0, hit_i = 1'b0;
  logic [LINES*TAPS-1:0] taps_i = '0;
  logic [CNT_W-1:0]      cnt_early_i = '0, cnt_late_i = '0;
  logic                  valid_o, err_o;
  logic [OUT_W-1:0]      stamp_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tdc_stamp_enc i_tdc_stamp_enc (.*);

  function automatic logic [CNT_W-1:0] gray(logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [TAPS-1:0] therm(int n);
    return (n >= TAPS) ? '1 : (TAPS'(1) << n) - 1'b1;
  endfunction

  // Snapshot for true position f in quarter taps; line l leads by l quarters
  function automatic logic [LINES*TAPS-1:0] snap(int f);
    logic [LINES*TAPS-1:0] t;
    for (int l = 0; l < LINES; l++) t[l*TAPS +: TAPS] = therm((f + l) / 4);
    return t;
  endfunction

  task automatic chk(string req, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic fire(logic [LINES*TAPS-1:0] t, logic [CNT_W-1:0] e, logic [CNT_W-1:0] l);
    @(negedge clk_i);
    taps_i = t; cnt_early_i = e; cnt_late_i = l; hit_i = 1'b1;
    @(negedge clk_i);
    hit_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 valid", OUT_W'(valid_o), '0);
    chk("R10 stamp", stamp_o, '0);
    chk("R10 err", OUT_W'(err_o), '0);
  endtask

  // Hit in second half: early counter trusted, late is junk
  task automatic t_late_half(int f, logic [CNT_W-1:0] n);
    fire(snap(f), gray(n), 21'h15A5A);
    chk("R1 valid", OUT_W'(valid_o), 1);
    chk("R4/R6 stamp", stamp_o, {n, FINE_W'(f)});
    chk("R8 clean err", OUT_W'(err_o), 0);
  endtask

  // Hit in first half: late counter minus one, early is junk
  task automatic t_early_half(int f, logic [CNT_W-1:0] n);
    fire(snap(f), 21'h0F0F0, gray(n + 1'b1));
    chk("R5/R3 stamp", stamp_o, {n, FINE_W'(f)});
    chk("R8 clean err", OUT_W'(err_o), 0);
  endtask

  task automatic t_bubble;
    logic [LINES*TAPS-1:0] t;
    t = snap(40);
    t[TAPS-1:0] = therm(10) | (TAPS'(1) << 11);
    fire(t, 21'h1, gray(21'd77));
    chk("R7 line0 bubble fine", stamp_o, {21'd76, 7'd40});
    chk("R7 line0 bubble err", OUT_W'(err_o), 1);
    t = snap(41);
    t[2*TAPS +: TAPS] = therm(10) | (TAPS'(1) << 13);
    fire(t, 21'h1, gray(21'd9));
    chk("R7 line2 bubble fine", stamp_o, {21'd8, 7'd41});
    chk("R7 line2 bubble err", OUT_W'(err_o), 1);
  endtask

  task automatic t_no_edge;
    logic [LINES*TAPS-1:0] t;
    t = snap(124);
    t[TAPS-1:0] = '1;
    fire(t, gray(21'd500), 21'h3);
    chk("R8 all-ones stamp", stamp_o, {21'd500, 7'd124});
    chk("R8 all-ones err", OUT_W'(err_o), 1);
  endtask

  task automatic t_hold;
    logic [OUT_W-1:0] prev;
    logic             perr;
    fire(snap(100), gray(21'd3), 21'h0);
    prev = stamp_o; perr = err_o;
    taps_i = '1; cnt_early_i = 21'h1FFFF; cnt_late_i = 21'h0ABCD;
    @(negedge clk_i);
    chk("R1 idle valid", OUT_W'(valid_o), 0);
    chk("R9 hold stamp", stamp_o, prev);
    chk("R9 hold err", OUT_W'(err_o), OUT_W'(perr));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    t_late_half(100, 21'd12345);            // R4
    t_late_half(64, 21'h0AAAA);             // R4 boundary
    t_late_half(127, 21'h1FFFFF);           // R3 top bin, R6 max count
    t_early_half(63, 21'd4242);             // R5 boundary
    t_early_half(0, 21'd1);                 // R2 bin 0
    t_early_half(5, 21'h12345);             // R3 offset
    t_early_half(10, 21'h1FFFFF);           // R5 wrap: late reads 0
    t_bubble;                               // R7
    t_no_edge;                              // R8
    t_hold;                                 // R9
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule